// File: doc/BRIEF.md
# Transmit Descriptor Evaluator

This block decides what happens to each transmit ring descriptor that a poller brings in. A poll tick, or the end of a frame, makes it fetch the descriptor at the current ring index. An entry that software has not handed over is left alone. An owned entry that cannot start a frame is handed back. An owned entry that starts a frame has its buffer streamed to the transmit FIFO by an external data mover.

While the first buffer of a multi-buffer frame is moving, the block reads the following ring entry once into a shadow register set. If that entry turns out not to be owned, the frame cannot continue. The block finishes the current buffer, writes that descriptor back with an error mark, raises a sticky fatal flag and turns transmit off until the next initialization.

Descriptor memory, write-back and data mover are each reached through a request/acknowledge port. The ring size is a power of two, loaded at initialization.

Top module: `tx_desc_eval`

## Requirements
- R1: A fetched descriptor whose ownership bit is 0 causes no write-back, no transfer and no index change. The same index is read again on the next poll tick.
- R2: An owned descriptor with start-of-packet 0 is written back with ownership cleared and `wb_err` 0. The index then advances, and the next entry is read at once without waiting for a poll tick.
- R3: An owned descriptor with length 0 is handed back like R2 with no transfer. This applies whatever its start/end flags are, including the illegal case of start 0 with end 1.
- R4: An owned descriptor with start-of-packet 1 and a non-zero length drives `mv_req` with its address and length until `mv_end`. It is then written back with ownership cleared and the index advances. Only one of `rd_req`, `wb_req`, `mv_req` is high in any cycle.
- R5: In a frame of more than one buffer, exactly one lookahead read of index+1 is made, after the first `mv_beat` of the first buffer. A single-buffer frame (end-of-packet 1) makes none. Buffers beyond the looked-ahead one are read from the ring in turn.
- R6: The lookahead copies address, length and flags into the `la_*` outputs whatever that entry's ownership bit is.
- R7: If the looked-ahead entry is not owned, the current buffer still completes. Its descriptor is then written back with `wb_err`=1 (buffer error plus underflow), and `fatal` rises while `tx_en` falls. The index stays put, and no port request is made while `fatal` is 1.
- R8: `init` clears `fatal`, sets `tx_en`, resets the index to 0 and loads the ring size as 2^`cfg_ring_lg`. `fatal` never clears otherwise.
- R9: The index advances as (index+1) modulo the ring size, so it wraps from the last entry to 0.
- R10: The index changes only in the cycle after a write-back handshake (`wb_req` and `wb_ack` both high) without error, or after `init`. A write-back request is held until acknowledged.
- R11: After reset and before the first `init`, `tx_en` is 0 and poll ticks cause no descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Re-initialization pulse |
| cfg_ring_lg | input | LG_W | log2 of ring size, sampled on `init` |
| poll_go | input | 1 | Poll timer expiry tick |
| rd_req | output | 1 | Descriptor read request |
| rd_idx | output | IDX_W | Ring index to read |
| rd_ack | input | 1 | Read data valid, one cycle |
| rd_own | input | 1 | Read ownership bit |
| rd_stp | input | 1 | Read start-of-packet flag |
| rd_enp | input | 1 | Read end-of-packet flag |
| rd_len | input | LEN_W | Read buffer length |
| rd_addr | input | ADDR_W | Read buffer address |
| wb_req | output | 1 | Write-back request (clears ownership) |
| wb_idx | output | IDX_W | Ring index to write back |
| wb_err | output | 1 | Write-back also sets buffer-error and underflow |
| wb_ack | input | 1 | Write-back accepted |
| mv_req | output | 1 | Data mover enable for current buffer |
| mv_addr | output | ADDR_W | Current buffer address |
| mv_len | output | LEN_W | Current buffer length |
| mv_beat | input | 1 | One data transfer completed |
| mv_end | input | 1 | Last transfer of the buffer (with `mv_beat`) |
| la_valid | output | 1 | Shadow holds an unconsumed lookahead |
| la_own | output | 1 | Shadow ownership bit |
| la_stp | output | 1 | Shadow start-of-packet flag |
| la_enp | output | 1 | Shadow end-of-packet flag |
| la_len | output | LEN_W | Shadow length |
| la_addr | output | ADDR_W | Shadow address |
| tx_en | output | 1 | Transmit enabled |
| fatal | output | 1 | Sticky underrun error |
| cur_idx | output | IDX_W | Current ring index |

## Verification
A corrupted index or ring mask shows on `cur_idx` in the cycle after the next write-back acknowledge. The reference model tracks the index from write-back handshakes alone, so a slip is caught within one clock. A state machine that takes a wrong branch on a fetched entry shows up, at the latest when the next request appears, as a missing or extra write-back, a transfer of the wrong address, or a read at the wrong index. A lost underrun mark shows as `wb_err` low and `fatal` staying clear on the frame's first write-back.

// File: rtl/tde_pkg.sv
package tde_pkg;

    localparam int LEN_W  = 12;
    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RET,
        ST_MOVE,
        ST_LOOK,
        ST_DONE,
        ST_CHAIN
    } tde_state_e;

    typedef struct packed {
        logic              own;
        logic              stp;
        logic              enp;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } tde_desc_t;

    // Owned entry that cannot open a frame, or carries no data.
    function automatic logic hand_back(input tde_desc_t d);
        return d.own && (!d.stp || (d.len == '0));
    endfunction

endpackage

// File: rtl/tde_ring_ptr.sv
module tde_ring_ptr #(
    parameter int IDX_W = 4,
    parameter int LG_W  = $clog2(IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [LG_W-1:0]  cfg_lg,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt,
    output logic [IDX_W-1:0] mask
);
    logic [IDX_W-1:0] idx_q, mask_q, mask_d;

    for (genvar g = 0; g < IDX_W; g++) begin : g_mask
        assign mask_d[g] = (LG_W'(g) < cfg_lg);
    end

    assign nxt  = (idx_q + {{(IDX_W-1){1'b0}}, 1'b1}) & mask_q;
    assign idx  = idx_q;
    assign mask = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mask_q <= '0;
        end else if (init) begin
            idx_q  <= '0;
            mask_q <= mask_d;
        end else if (adv) begin
            idx_q  <= nxt;
        end
    end
endmodule

// File: rtl/tde_shadow.sv
module tde_shadow
    import tde_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      load,
    input  tde_desc_t d,
    output logic      valid,
    output tde_desc_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= d;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_desc_eval.sv
module tx_desc_eval
    import tde_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LG_W  = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [LG_W-1:0]   cfg_ring_lg,
    input  logic              poll_go,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_ack,
    input  logic              rd_own,
    input  logic              rd_stp,
    input  logic              rd_enp,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wb_req,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_err,
    input  logic              wb_ack,
    output logic              mv_req,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    input  logic              mv_beat,
    input  logic              mv_end,
    output logic              la_valid,
    output logic              la_own,
    output logic              la_stp,
    output logic              la_enp,
    output logic [LEN_W-1:0]  la_len,
    output logic [ADDR_W-1:0] la_addr,
    output logic              tx_en,
    output logic              fatal,
    output logic [IDX_W-1:0]  cur_idx
);
    tde_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [LEN_W-1:0]  len_q, len_d;
    logic              enp_q, enp_d;
    logic              la_done_q, la_done_d;
    logic              pend_q, pend_d;
    logic              und_q, und_d;
    logic              fat_q, fat_d;
    logic              txen_q, txen_d;
    logic              adv, sh_load, sh_clr, sh_valid;
    logic [IDX_W-1:0]  idx, nxt, ring_mask;
    tde_desc_t         rd_desc, sh_q;

    assign rd_desc = '{own: rd_own, stp: rd_stp, enp: rd_enp, len: rd_len, addr: rd_addr};

    tde_ring_ptr #(.IDX_W(IDX_W), .LG_W(LG_W)) ring_i (
        .clk(clk), .rst(rst), .init(init), .cfg_lg(cfg_ring_lg),
        .adv(adv), .idx(idx), .nxt(nxt), .mask(ring_mask)
    );

    tde_shadow shadow_i (
        .clk(clk), .rst(rst), .clr(sh_clr | init), .load(sh_load & ~init),
        .d(rd_desc), .valid(sh_valid), .q(sh_q)
    );

    always_comb begin
        st_d      = st_q;
        addr_d    = addr_q;
        len_d     = len_q;
        enp_d     = enp_q;
        la_done_d = la_done_q;
        pend_d    = pend_q;
        und_d     = und_q;
        fat_d     = fat_q;
        txen_d    = txen_q;
        rd_req    = 1'b0;
        rd_idx    = idx;
        wb_req    = 1'b0;
        wb_err    = 1'b0;
        mv_req    = 1'b0;
        adv       = 1'b0;
        sh_load   = 1'b0;
        sh_clr    = 1'b0;
        unique case (st_q)
            ST_IDLE: if (poll_go && txen_q && !fat_q) st_d = ST_FETCH;
            ST_FETCH: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (!rd_own) begin
                        st_d = ST_IDLE;
                    end else if (hand_back(rd_desc)) begin
                        st_d = ST_RET;
                    end else begin
                        addr_d    = rd_addr;
                        len_d     = rd_len;
                        enp_d     = rd_enp;
                        la_done_d = 1'b0;
                        pend_d    = 1'b0;
                        und_d     = 1'b0;
                        sh_clr    = 1'b1;
                        st_d      = ST_MOVE;
                    end
                end
            end
            ST_RET: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    adv  = 1'b1;
                    st_d = ST_FETCH;
                end
            end
            ST_MOVE: begin
                mv_req = 1'b1;
                if (mv_beat) begin
                    if (!la_done_q && !enp_q) begin
                        la_done_d = 1'b1;
                        pend_d    = mv_end;
                        st_d      = ST_LOOK;
                    end else if (mv_end) begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_LOOK: begin
                rd_req = 1'b1;
                rd_idx = nxt;
                if (rd_ack) begin
                    sh_load = 1'b1;
                    und_d   = !rd_own;
                    st_d    = pend_q ? ST_DONE : ST_MOVE;
                end
            end
            ST_DONE: begin
                wb_req = 1'b1;
                wb_err = und_q;
                if (wb_ack) begin
                    if (und_q) begin
                        fat_d  = 1'b1;
                        txen_d = 1'b0;
                        st_d   = ST_IDLE;
                    end else begin
                        adv = 1'b1;
                        if (enp_q) begin
                            st_d = ST_FETCH;
                        end else if (sh_valid) begin
                            addr_d = sh_q.addr;
                            len_d  = sh_q.len;
                            enp_d  = sh_q.enp;
                            sh_clr = 1'b1;
                            st_d   = (sh_q.len == '0) ? ST_DONE : ST_MOVE;
                        end else begin
                            st_d = ST_CHAIN;
                        end
                    end
                end
            end
            ST_CHAIN: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (!rd_own) begin
                        fat_d  = 1'b1;
                        txen_d = 1'b0;
                        st_d   = ST_IDLE;
                    end else begin
                        addr_d = rd_addr;
                        len_d  = rd_len;
                        enp_d  = rd_enp;
                        st_d   = (rd_len == '0) ? ST_DONE : ST_MOVE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            addr_q    <= '0;
            len_q     <= '0;
            enp_q     <= 1'b0;
            la_done_q <= 1'b0;
            pend_q    <= 1'b0;
            und_q     <= 1'b0;
            fat_q     <= 1'b0;
            txen_q    <= 1'b0;
        end else if (init) begin
            st_q      <= ST_IDLE;
            la_done_q <= 1'b0;
            pend_q    <= 1'b0;
            und_q     <= 1'b0;
            fat_q     <= 1'b0;
            txen_q    <= 1'b1;
        end else begin
            st_q      <= st_d;
            addr_q    <= addr_d;
            len_q     <= len_d;
            enp_q     <= enp_d;
            la_done_q <= la_done_d;
            pend_q    <= pend_d;
            und_q     <= und_d;
            fat_q     <= fat_d;
            txen_q    <= txen_d;
        end
    end

    assign wb_idx   = idx;
    assign mv_addr  = addr_q;
    assign mv_len   = len_q;
    assign la_valid = sh_valid;
    assign la_own   = sh_q.own;
    assign la_stp   = sh_q.stp;
    assign la_enp   = sh_q.enp;
    assign la_len   = sh_q.len;
    assign la_addr  = sh_q.addr;
    assign tx_en    = txen_q;
    assign fatal    = fat_q;
    assign cur_idx  = idx;
endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             init,
    input logic             rd_req,
    input logic             wb_req,
    input logic             wb_ack,
    input logic             wb_err,
    input logic             mv_req,
    input logic             tx_en,
    input logic             fatal,
    input logic [IDX_W-1:0] cur_idx,
    input logic [IDX_W-1:0] ring_mask
);
    AST_IDX_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (cur_idx != $past(cur_idx)) && !$past(init) |-> $past(wb_req && wb_ack && !wb_err)); // R10

    AST_WB_HELD: assert property (@(posedge clk) disable iff (rst || init)
        wb_req && !wb_ack |=> wb_req); // R10

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cur_idx != $past(cur_idx)) && !$past(init)
            |-> cur_idx == (($past(cur_idx) + 1'b1) & ring_mask)); // R9

    AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        fatal |-> !rd_req && !wb_req && !mv_req); // R7

    AST_FATAL_TXOFF: assert property (@(posedge clk) disable iff (rst)
        fatal |-> !tx_en); // R7

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fatal && !init |=> fatal); // R8

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_req, wb_req, mv_req})); // R4

    AST_NO_READ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !rd_req); // R11
endmodule

bind tx_desc_eval tde_checker #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .init(init), .rd_req(rd_req), .wb_req(wb_req),
    .wb_ack(wb_ack), .wb_err(wb_err), .mv_req(mv_req), .tx_en(tx_en),
    .fatal(fatal), .cur_idx(cur_idx), .ring_mask(ring_mask)
);

// File: tb/tx_desc_eval_tb_top.sv
module tx_desc_eval_tb_top;
    localparam int IDX_W = 4;
    localparam int LG_W  = 3;

    logic        clk = 1'b0;
    logic        rst, init, poll_go;
    logic [2:0]  cfg_ring_lg;
    logic        rd_req, rd_ack, rd_own, rd_stp, rd_enp;
    logic [3:0]  rd_idx, wb_idx, cur_idx;
    logic [11:0] rd_len, mv_len, la_len;
    logic [31:0] rd_addr, mv_addr, la_addr;
    logic        wb_req, wb_err, wb_ack, mv_req, mv_beat, mv_end;
    logic        la_valid, la_own, la_stp, la_enp, tx_en, fatal;

    always #5 clk = ~clk;

    tx_desc_eval #(.IDX_W(IDX_W), .LG_W(LG_W)) dut_i (
        .clk(clk), .rst(rst), .init(init), .cfg_ring_lg(cfg_ring_lg), .poll_go(poll_go),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_own(rd_own),
        .rd_stp(rd_stp), .rd_enp(rd_enp), .rd_len(rd_len), .rd_addr(rd_addr),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_err(wb_err), .wb_ack(wb_ack),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_beat(mv_beat), .mv_end(mv_end),
        .la_valid(la_valid), .la_own(la_own), .la_stp(la_stp), .la_enp(la_enp),
        .la_len(la_len), .la_addr(la_addr), .tx_en(tx_en), .fatal(fatal), .cur_idx(cur_idx)
    );

    // Descriptor ring model
    logic        m_own[16], m_stp[16], m_enp[16];
    logic [11:0] m_len[16];
    logic [31:0] m_addr[16];

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wb = 0, rem = 0;
    int last_rd = 0;
    logic last_err = 1'b0;
    logic [31:0] moved[$];
    logic [3:0] e_idx = '0, e_mask = '0;
    logic e_en = 1'b0, e_fat = 1'b0;
    logic p_init, p_rd, p_wb, p_wb_err, p_end;
    logic [3:0] p_rd_idx, p_wb_idx;
    logic [31:0] p_addr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_d(input int i, input bit o, input bit s, input bit e,
                         input int l, input logic [31:0] a);
        m_own[i] = o; m_stp[i] = s; m_enp[i] = e; m_len[i] = 12'(l); m_addr[i] = a;
    endtask

    // Environment and reference model, evaluated just after each falling edge
    task automatic env_step();
        if (rst) begin
            rd_ack = 0; wb_ack = 0; mv_beat = 0; mv_end = 0;
            p_init = 0; p_rd = 0; p_wb = 0; p_wb_err = 0; p_end = 0;
            p_rd_idx = '0; p_wb_idx = '0; p_addr = '0;
            e_idx = '0; e_en = 0; e_fat = 0; rem = 0;
            return;
        end
        if (p_init) begin
            e_idx = '0; e_en = 1; e_fat = 0; e_mask = 4'((1 << cfg_ring_lg) - 1);
        end else if (p_wb) begin
            m_own[p_wb_idx] = 1'b0;
            n_wb++;
            last_err = p_wb_err;
            if (p_wb_err) begin e_fat = 1; e_en = 0; end
            else e_idx = (e_idx + 4'd1) & e_mask;
        end
        if (p_rd) begin n_rd++; last_rd = int'(p_rd_idx); end
        if (p_end) moved.push_back(p_addr);
        chk(cur_idx == e_idx, "R10 index", cur_idx, e_idx);
        chk(tx_en == e_en, "R8 tx_en", tx_en, e_en);
        chk(fatal == e_fat, "R7 fatal", fatal, e_fat);
        rd_ack = rd_req && !rd_ack;
        if (rd_ack) begin
            rd_own = m_own[rd_idx]; rd_stp = m_stp[rd_idx]; rd_enp = m_enp[rd_idx];
            rd_len = m_len[rd_idx]; rd_addr = m_addr[rd_idx];
        end
        wb_ack = wb_req && !wb_ack;
        if (mv_req) begin
            if (rem == 0) rem = (int'(mv_len) + 3) / 4;
            rem--;
            mv_beat = 1; mv_end = (rem == 0);
        end else begin
            mv_beat = 0; mv_end = 0;
        end
        p_init = init;
        p_rd = rd_req && rd_ack; p_rd_idx = rd_idx;
        p_wb = wb_req && wb_ack; p_wb_idx = wb_idx; p_wb_err = wb_err;
        p_end = mv_req && mv_beat && mv_end; p_addr = mv_addr;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_init();
        init = 1; cyc(1); init = 0; cyc(2);
    endtask

    task automatic poll();
        poll_go = 1; cyc(1); poll_go = 0; cyc(40);
    endtask

    task automatic main_seq();
        int r0, w0;
        for (int i = 0; i < 16; i++) set_d(i, 0, 0, 0, 0, 32'h0);
        rst = 1; init = 0; poll_go = 0; cfg_ring_lg = 3'd2;
        rd_own = 0; rd_stp = 0; rd_enp = 0; rd_len = '0; rd_addr = '0;
        cyc(3);
        chk(tx_en == 0 && fatal == 0, "R11 reset tx_en/fatal", {tx_en, fatal}, 0);
        chk(!rd_req && !wb_req && !mv_req, "R11 reset requests", {rd_req, wb_req, mv_req}, 0);
        chk(cur_idx == 0 && la_valid == 0, "R11 reset index", cur_idx, 0);
        rst = 0; cyc(1);
        // R11: poll before init is ignored
        poll();
        chk(n_rd == 0, "R11 no read before init", n_rd, 0);
        pulse_init();
        chk(tx_en == 1 && cur_idx == 0, "R8 init", {tx_en, cur_idx}, 16);
        // R1: unowned entry, re-read on next poll
        poll();
        chk(n_rd == 1 && n_wb == 0 && cur_idx == 0, "R1 unowned first poll", n_rd, 1);
        poll();
        chk(n_rd == 2 && last_rd == 0, "R1 same entry re-read", last_rd, 0);
        // R2/R3: orphan zero-length (illegal flags) then zero-length start
        set_d(0, 1, 0, 1, 0, 32'h100);
        set_d(1, 1, 1, 0, 0, 32'h200);
        r0 = n_rd; w0 = n_wb;
        poll();
        chk(n_wb - w0 == 2 && cur_idx == 2, "R2 returned entries", n_wb - w0, 2);
        chk(n_rd - r0 == 3, "R2 next fetched without poll", n_rd - r0, 3);
        chk(!m_own[0] && !m_own[1] && !last_err, "R3 ownership cleared", {m_own[0], m_own[1]}, 0);
        chk(moved.size() == 0, "R3 no transfer", moved.size(), 0);
        // R4: single-buffer frame
        set_d(2, 1, 1, 1, 8, 32'hA000);
        poll();
        chk(moved.size() == 1 && moved[0] == 32'hA000, "R4 buffer moved", moved[moved.size()-1], 32'hA000);
        chk(cur_idx == 3 && !m_own[2], "R4 write-back and advance", cur_idx, 3);
        chk(la_valid == 0 && la_addr == 0, "R5 no lookahead on single buffer", la_addr, 0);
        // R5/R9: two-buffer chain wrapping 3 -> 0 -> 1
        set_d(3, 1, 1, 0, 8, 32'hB000);
        set_d(0, 1, 0, 1, 4, 32'hC000);
        poll();
        chk(moved.size() == 3 && moved[1] == 32'hB000 && moved[2] == 32'hC000, "R5 chain order",
            moved[moved.size()-1], 32'hC000);
        chk(la_addr == 32'hC000 && la_own == 1 && la_len == 4, "R5 lookahead contents", la_addr, 32'hC000);
        chk(cur_idx == 1, "R9 wrap", cur_idx, 1);
        chk(la_valid == 0, "R5 shadow consumed", la_valid, 0);
        // R6/R7: lookahead entry unowned -> underrun
        set_d(1, 1, 1, 0, 12, 32'hD000);
        set_d(2, 0, 0, 1, 20, 32'hE000);
        poll();
        chk(moved.size() == 4 && moved[3] == 32'hD000, "R7 current buffer finished", moved[moved.size()-1], 32'hD000);
        chk(la_addr == 32'hE000 && la_len == 20 && la_own == 0, "R6 unowned captured", la_addr, 32'hE000);
        chk(last_err == 1 && fatal == 1 && tx_en == 0, "R7 error write-back", {last_err, fatal, tx_en}, 6);
        chk(cur_idx == 1, "R7 index held", cur_idx, 1);
        r0 = n_rd;
        poll();
        chk(n_rd == r0, "R7 polls ignored while fatal", n_rd, r0);
        // R8: init recovers
        pulse_init();
        chk(fatal == 0 && tx_en == 1 && cur_idx == 0, "R8 re-init", {fatal, tx_en}, 1);
        // R5: three-buffer frame, third read from the ring
        set_d(0, 1, 1, 0, 4, 32'hF000);
        set_d(1, 1, 0, 0, 4, 32'hF100);
        set_d(2, 1, 0, 1, 4, 32'hF200);
        w0 = n_wb;
        poll();
        chk(moved.size() == 7 && moved[4] == 32'hF000 && moved[5] == 32'hF100 && moved[6] == 32'hF200,
            "R5 three buffers", moved[moved.size()-1], 32'hF200);
        chk(n_wb - w0 == 3 && cur_idx == 3, "R4 three write-backs", n_wb - w0, 3);
    endtask

    initial begin
        rst = 1; init = 0; poll_go = 0; cfg_ring_lg = 3'd2;
        rd_ack = 0; wb_ack = 0; mv_beat = 0; mv_end = 0;
        fork
            forever begin @(negedge clk); #1; env_step(); end
            main_seq();
            begin repeat (20000) @(posedge clk); chk(0, "watchdog", 0, 1); end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule